// File: doc/BRIEF.md
# Dual Timer/Counter With Four Count Modes

This block holds two timer/counter units, each built from a low and a high count byte. A shared 8-bit mode register and a shared control register configure them. Each unit either counts machine cycles, marked by an enable pulse that arrives from outside, or counts falling edges on its own external count pin. The unit's run bit qualifies counting. An optional gate bit adds a second condition, so that an external pin level can frame a pulse-width measurement.

Each unit has four count shapes. The first is a 13-bit count, which uses the low byte's lower bits as a prescaler. The others are a 16-bit count, an 8-bit count that reloads from the high byte, and a split mode. In split mode, unit 0's high byte becomes a separate 8-bit timer that runs on unit 1's run bit and raises unit 1's flag. A wrap of either unit sets that unit's overflow flag, and an acknowledge input clears the flag. Unit 1's overflow also drives a one-cycle rate tick for a serial port.

Top module: `dual_tmr_ctr`

## Requirements
- R1: After reset both counts, both overflow flags, the run bits, the mode register and the rate tick are zero.
- R2: In timer mode (select bit 0) a qualified unit adds one for each clock in which `mc_tick_i` is high, and it holds while `mc_tick_i` is low.
- R3: A unit counts only while its run bit is 1 and either its gate bit is 0 or its `gate_pin_i` bit is high. Mode register nibble layout (unit 0 in bits 3:0, unit 1 in bits 7:4): bit 3 gate, bit 2 external select, bits 1:0 mode. Control register (address 1): bit 0 runs unit 0, bit 1 runs unit 1, bits 4 and 5 are flags 0 and 1.
- R4: In counter mode (select bit 1) a unit samples `cnt_pin_i` on each `mc_tick_i`. It adds one on a tick where the previous sample was 1 and the present pin is 0. Pin activity between ticks is not counted.
- R5: Mode 01 is a 16-bit count. A wrap from FFFF to 0000 sets the unit's flag, where `flag_o[0]` is unit 0 and `flag_o[1]` is unit 1.
- R6: Mode 00 is a 13-bit count: the high byte and low byte bits 4:0, with low byte bits 7:5 held. A carry out of bit 4 steps the high byte, and a full wrap sets the flag.
- R7: `ack_i[k]` clears flag k on the next edge unless an overflow sets it in the same cycle.
- R8: Changing the run bits leaves the count bytes unchanged.
- R9: A register write (addresses: 0 mode, 1 control, 2 low 0, 3 high 0, 4 low 1, 5 high 1) to a count byte wins over a same-cycle increment of that byte.
- R10: In mode 10 the low byte counts. On its wrap it loads the high byte's value and sets the flag, and the high byte is unchanged.
- R11: When unit 0 is in mode 11, unit 0's low byte counts under unit 0's controls and sets flag 0. Its high byte counts machine cycles while run bit 1 is set, and its wrap sets flag 1. Unit 1's own wrap then no longer sets flag 1. Unit 1 placed in mode 11 holds its count.
- R12: `baud_tick_o` is high for one cycle after each unit 1 wrap, including when unit 0's split mode holds flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mc_tick_i | input | 1 | Machine-cycle enable pulse |
| cnt_pin_i | input | 2 | External count pins, one per unit |
| gate_pin_i | input | 2 | External gate pins, one per unit |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select |
| wr_data_i | input | BYTE_W | Write data |
| ack_i | input | 2 | Interrupt acknowledge per flag |
| cnt0_o | output | 2*BYTE_W | Unit 0 count {high, low} |
| cnt1_o | output | 2*BYTE_W | Unit 1 count {high, low} |
| flag_o | output | 2 | Overflow flags |
| baud_tick_o | output | 1 | Unit 1 overflow pulse |

## Verification
The bench builds the block with its defaults, BYTE_W of 8 and PRESC_W of 5. Those values keep every wrap reachable in one or two ticks once the bench preloads the count bytes. That covers the 13-bit carry out of bit 4, the reload boundary at FF and the 16-bit wrap. With the same defaults the bench can also check that split mode hands flag 1 to unit 0's high byte while unit 1 still drives the rate tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    REG_MODE = 3'd0,
    REG_CTRL = 3'd1,
    REG_LO0  = 3'd2,
    REG_HI0  = 3'd3,
    REG_LO1  = 3'd4,
    REG_HI1  = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_13B    = 2'b00,
    MODE_16B    = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_SPLIT  = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e mode;
  } unit_cfg_t;
endpackage

// File: rtl/tmr_event.sv
module tmr_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic gate_en_i,
  input  logic gate_pin_i,
  input  logic ext_sel_i,
  input  logic cnt_pin_i,
  output logic inc_o
);
  logic samp_q;
  logic qual;
  logic src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     samp_q <= 1'b0;
    else if (tick_i) samp_q <= cnt_pin_i;
  end

  assign qual  = run_i & (~gate_en_i | gate_pin_i);
  // falling edge seen between two consecutive tick samples
  assign src   = ext_sel_i ? (samp_q & ~cnt_pin_i) : 1'b1;
  assign inc_o = tick_i & qual & src;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRESC_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tmr_mode_e         mode_i,
  input  logic              inc_i,
  input  logic              inc_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_o,
  output logic              ovf_hi_o
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0]  ONE_B = BYTE_W'(1);
  localparam logic [PRESC_W-1:0] ONE_P = PRESC_W'(1);
  localparam logic [CNT_W-1:0]   ONE_W = CNT_W'(1);

  logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;

  always_comb begin
    lo_n     = lo_q;
    hi_n     = hi_q;
    ovf_o    = 1'b0;
    ovf_hi_o = 1'b0;
    unique case (mode_i)
      MODE_13B: if (inc_i) begin
        lo_n[PRESC_W-1:0] = lo_q[PRESC_W-1:0] + ONE_P;
        if (&lo_q[PRESC_W-1:0]) begin
          hi_n  = hi_q + ONE_B;
          ovf_o = &hi_q;
        end
      end
      MODE_16B: if (inc_i) begin
        {hi_n, lo_n} = {hi_q, lo_q} + ONE_W;
        ovf_o        = &{hi_q, lo_q};
      end
      MODE_RELOAD: if (inc_i) begin
        if (&lo_q) begin
          lo_n  = hi_q;
          ovf_o = 1'b1;
        end else begin
          lo_n = lo_q + ONE_B;
        end
      end
      default: begin
        // split: two independent byte timers
        if (inc_i) begin
          lo_n  = lo_q + ONE_B;
          ovf_o = &lo_q;
        end
        if (inc_hi_i) begin
          hi_n     = hi_q + ONE_B;
          ovf_hi_o = &hi_q;
        end
      end
    endcase
    if (wr_lo_i) lo_n = wr_data_i;
    if (wr_hi_i) hi_n = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/dual_tmr_ctr.sv
module dual_tmr_ctr
  import tmr_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRESC_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mc_tick_i,
  input  logic [1:0]          cnt_pin_i,
  input  logic [1:0]          gate_pin_i,
  input  logic                wr_en_i,
  input  logic [2:0]          wr_addr_i,
  input  logic [BYTE_W-1:0]   wr_data_i,
  input  logic [1:0]          ack_i,
  output logic [2*BYTE_W-1:0] cnt0_o,
  output logic [2*BYTE_W-1:0] cnt1_o,
  output logic [1:0]          flag_o,
  output logic                baud_tick_o
);
  localparam int N_UNITS  = 2;
  localparam int NIB_W    = 4;
  localparam int RUN_LSB  = 0;
  localparam int FLAG_LSB = 4;

  reg_sel_e sel;
  logic     wr_mode, wr_ctrl;
  logic [N_UNITS*NIB_W-1:0] mode_q;
  logic [N_UNITS-1:0] run_q, flag_q, flag_set;
  logic [N_UNITS-1:0] inc, inc_hi, ovf, ovf_hi, wr_lo, wr_hi;
  logic [BYTE_W-1:0]  lo [N_UNITS];
  logic [BYTE_W-1:0]  hi [N_UNITS];
  unit_cfg_t          cfg [N_UNITS];
  logic               baud_q;

  assign sel     = reg_sel_e'(wr_addr_i);
  assign wr_mode = wr_en_i && (sel == REG_MODE);
  assign wr_ctrl = wr_en_i && (sel == REG_CTRL);
  assign wr_lo[0] = wr_en_i && (sel == REG_LO0);
  assign wr_hi[0] = wr_en_i && (sel == REG_HI0);
  assign wr_lo[1] = wr_en_i && (sel == REG_LO1);
  assign wr_hi[1] = wr_en_i && (sel == REG_HI1);

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic ev;
    assign cfg[u] = unit_cfg_t'(mode_q[u*NIB_W +: NIB_W]);

    tmr_event u_ev (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (mc_tick_i),
      .run_i      (run_q[u]),
      .gate_en_i  (cfg[u].gate),
      .gate_pin_i (gate_pin_i[u]),
      .ext_sel_i  (cfg[u].ext),
      .cnt_pin_i  (cnt_pin_i[u]),
      .inc_o      (ev)
    );

    if (u == 0) begin : g_lead
      assign inc[u]    = ev;
      // high byte timer borrows unit 1 run bit
      assign inc_hi[u] = mc_tick_i & run_q[1];
    end else begin : g_follow
      // split mode on this unit means stopped
      assign inc[u]    = ev & (cfg[u].mode != MODE_SPLIT);
      assign inc_hi[u] = 1'b0;
    end

    tmr_unit #(.BYTE_W(BYTE_W), .PRESC_W(PRESC_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (cfg[u].mode),
      .inc_i     (inc[u]),
      .inc_hi_i  (inc_hi[u]),
      .wr_lo_i   (wr_lo[u]),
      .wr_hi_i   (wr_hi[u]),
      .wr_data_i (wr_data_i),
      .lo_o      (lo[u]),
      .hi_o      (hi[u]),
      .ovf_o     (ovf[u]),
      .ovf_hi_o  (ovf_hi[u])
    );
  end

  assign flag_set[0] = ovf[0];
  assign flag_set[1] = (cfg[0].mode == MODE_SPLIT) ? ovf_hi[0] : ovf[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
      baud_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wr_data_i;
      if (wr_ctrl) run_q  <= wr_data_i[RUN_LSB +: N_UNITS];
      for (int k = 0; k < N_UNITS; k++) begin
        if (flag_set[k])    flag_q[k] <= 1'b1;
        else if (wr_ctrl)   flag_q[k] <= wr_data_i[FLAG_LSB + k];
        else if (ack_i[k])  flag_q[k] <= 1'b0;
      end
      baud_q <= ovf[1];
    end
  end

  assign cnt0_o      = {hi[0], lo[0]};
  assign cnt1_o      = {hi[1], lo[1]};
  assign flag_o      = flag_q;
  assign baud_tick_o = baud_q;
endmodule

// File: rtl/dual_tmr_ctr_chk.sv
module dual_tmr_ctr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mc_tick_i,
  input logic             wr_en_i,
  input logic [1:0]       ack_i,
  input logic [CNT_W-1:0] cnt0_o,
  input logic [CNT_W-1:0] cnt1_o,
  input logic [1:0]       flag_o,
  input logic             baud_tick_o,
  input logic [1:0]       run_i,
  input logic [7:0]       mode_i,
  input logic [1:0]       set_i,
  input logic             wr_ctrl_i
);
  assert_hold_no_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mc_tick_i && !wr_en_i) |=> ($stable(cnt0_o) && $stable(cnt1_o)));

  assert_run_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i[0] && mode_i[1:0] != 2'b11 && !wr_en_i) |=> $stable(cnt0_o));

  assert_flag_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o[0]) |-> $past(set_i[0] || wr_ctrl_i));

  assert_ack_clear0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i[0] && !set_i[0] && !wr_ctrl_i) |=> !flag_o[0]);

  assert_ack_clear1_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i[1] && !set_i[1] && !wr_ctrl_i) |=> !flag_o[1]);

  assert_unit1_stopped_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[5:4] == 2'b11 && !wr_en_i) |=> $stable(cnt1_o));

  assert_tick_needs_cycle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_tick_o |-> $past(mc_tick_i));
endmodule

bind dual_tmr_ctr dual_tmr_ctr_chk #(.CNT_W(2*BYTE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mc_tick_i   (mc_tick_i),
  .wr_en_i     (wr_en_i),
  .ack_i       (ack_i),
  .cnt0_o      (cnt0_o),
  .cnt1_o      (cnt1_o),
  .flag_o      (flag_o),
  .baud_tick_o (baud_tick_o),
  .run_i       (run_q),
  .mode_i      (mode_q),
  .set_i       (flag_set),
  .wr_ctrl_i   (wr_ctrl)
);

// File: tb/tb_dual_tmr_ctr.sv
module tb_dual_tmr_ctr;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mc_tick = 1'b0;
  logic [1:0]  cnt_pin = 2'b00;
  logic [1:0]  gate_pin = 2'b00;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [7:0]  wr_data = 8'h00;
  logic [1:0]  ack = 2'b00;
  logic [15:0] cnt0, cnt1;
  logic [1:0]  flags;
  logic        baud;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  string       req_q[$];
  int          sel_q[$];
  logic [15:0] exp_q[$];

  localparam int S_CNT0 = 0, S_CNT1 = 1, S_FLAG = 2, S_BAUD = 3;
  localparam logic [2:0] A_MODE = 3'd0, A_CTRL = 3'd1, A_LO0 = 3'd2,
                         A_HI0 = 3'd3, A_LO1 = 3'd4, A_HI1 = 3'd5;

  always #4 clk = ~clk;

  dual_tmr_ctr dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mc_tick_i   (mc_tick),
    .cnt_pin_i   (cnt_pin),
    .gate_pin_i  (gate_pin),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .ack_i       (ack),
    .cnt0_o      (cnt0),
    .cnt1_o      (cnt1),
    .flag_o      (flags),
    .baud_tick_o (baud)
  );

  // monitor: pops expected items, compares at the falling edge
  always @(negedge clk) begin
    while (req_q.size() > 0) begin
      string       r;
      int          s;
      logic [15:0] e, a;
      r = req_q.pop_front();
      s = sel_q.pop_front();
      e = exp_q.pop_front();
      case (s)
        S_CNT0:  a = cnt0;
        S_CNT1:  a = cnt1;
        S_FLAG:  a = {14'd0, flags};
        default: a = {15'd0, baud};
      endcase
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", r, s, a, e);
      end
    end
  end

  task automatic expect_val(input string r, input int s, input logic [15:0] e);
    req_q.push_back(r);
    sel_q.push_back(s);
    exp_q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    mc_tick = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    mc_tick = 1'b0;
  endtask

  task automatic ack_flag(input logic [1:0] k);
    ack = k;
    step(1);
    ack = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    expect_val("R1 cnt0", S_CNT0, 16'h0000);
    expect_val("R1 cnt1", S_CNT1, 16'h0000);
    expect_val("R1 flags", S_FLAG, 16'h0000);
    expect_val("R1 tick", S_BAUD, 16'h0000);
    rst_ni = 1'b1;
    step(1);

    // R2 timer mode, unit 0 only running
    wr(A_MODE, 8'h11);
    wr(A_CTRL, 8'h01);
    ticks(5);
    expect_val("R2 five ticks", S_CNT0, 16'h0005);
    expect_val("R3 unit1 run off", S_CNT1, 16'h0000);
    step(3);
    expect_val("R2 no tick hold", S_CNT0, 16'h0005);

    // R3 gate
    wr(A_MODE, 8'h19);
    ticks(4);
    expect_val("R3 gate low blocks", S_CNT0, 16'h0005);
    gate_pin = 2'b01;
    ticks(2);
    expect_val("R3 gate high counts", S_CNT0, 16'h0007);
    gate_pin = 2'b00;

    // R4 counter mode on falling edges between samples
    wr(A_MODE, 8'h15);
    cnt_pin = 2'b01; ticks(1);
    expect_val("R4 rise no count", S_CNT0, 16'h0007);
    cnt_pin = 2'b00; ticks(1);
    expect_val("R4 fall counts", S_CNT0, 16'h0008);
    ticks(2);
    expect_val("R4 steady low", S_CNT0, 16'h0008);
    cnt_pin = 2'b01; ticks(1);
    cnt_pin = 2'b00; ticks(1);
    cnt_pin = 2'b01; step(2);
    cnt_pin = 2'b00; step(2);
    ticks(1);
    expect_val("R4 edge between ticks ignored", S_CNT0, 16'h0009);

    // R5 16-bit wrap
    wr(A_MODE, 8'h11);
    wr(A_LO0, 8'hFE);
    wr(A_HI0, 8'hFF);
    ticks(1);
    expect_val("R5 at FFFF", S_CNT0, 16'hFFFF);
    expect_val("R5 no flag yet", S_FLAG, 16'h0000);
    ticks(1);
    expect_val("R5 wrap", S_CNT0, 16'h0000);
    expect_val("R5 flag0 set", S_FLAG, 16'h0001);
    ack_flag(2'b01);
    expect_val("R7 ack clears flag0", S_FLAG, 16'h0000);

    wr(A_LO1, 8'hFF);
    wr(A_HI1, 8'hFF);
    wr(A_CTRL, 8'h02);
    ticks(1);
    expect_val("R5 unit1 wrap", S_CNT1, 16'h0000);
    expect_val("R5 flag1 set", S_FLAG, 16'h0002);
    expect_val("R12 tick on unit1 wrap", S_BAUD, 16'h0001);
    expect_val("R3 unit0 idle", S_CNT0, 16'h0000);
    ack_flag(2'b10);
    expect_val("R7 ack clears flag1", S_FLAG, 16'h0000);
    expect_val("R12 tick one cycle", S_BAUD, 16'h0000);

    // R8 run bit changes keep counts
    wr(A_CTRL, 8'h01);
    ticks(3);
    wr(A_CTRL, 8'h00);
    wr(A_CTRL, 8'h01);
    expect_val("R8 count kept", S_CNT0, 16'h0003);

    // R6 13-bit mode
    wr(A_MODE, 8'h10);
    wr(A_LO0, 8'hFE);
    wr(A_HI0, 8'h12);
    ticks(1);
    expect_val("R6 prescale step", S_CNT0, 16'h12FF);
    ticks(1);
    expect_val("R6 carry, upper bits held", S_CNT0, 16'h13E0);
    wr(A_HI0, 8'hFF);
    wr(A_LO0, 8'h1F);
    ticks(1);
    expect_val("R6 full wrap", S_CNT0, 16'h0000);
    expect_val("R6 flag0", S_FLAG, 16'h0001);
    ack_flag(2'b01);

    // R9 write beats increment
    wr(A_MODE, 8'h11);
    wr(A_HI0, 8'h00);
    wr(A_LO0, 8'h10);
    mc_tick = 1'b1;
    wr(A_LO0, 8'h40);
    mc_tick = 1'b0;
    expect_val("R9 write wins", S_CNT0, 16'h0040);

    // R10 auto-reload
    wr(A_MODE, 8'h12);
    wr(A_HI0, 8'h80);
    wr(A_LO0, 8'hFE);
    ticks(1);
    expect_val("R10 before wrap", S_CNT0, 16'h80FF);
    ticks(1);
    expect_val("R10 reload", S_CNT0, 16'h8080);
    expect_val("R10 flag0", S_FLAG, 16'h0001);
    ticks(1);
    expect_val("R10 after reload", S_CNT0, 16'h8081);
    ack_flag(2'b01);

    // R11 split mode
    wr(A_MODE, 8'h13);
    wr(A_LO0, 8'h10);
    wr(A_HI0, 8'h10);
    wr(A_LO1, 8'hFE);
    wr(A_HI1, 8'hFF);
    wr(A_CTRL, 8'h01);
    ticks(2);
    expect_val("R11 high byte needs run1", S_CNT0, 16'h1012);
    wr(A_CTRL, 8'h03);
    ticks(2);
    expect_val("R11 both bytes count", S_CNT0, 16'h1214);
    expect_val("R11 unit1 wrapped", S_CNT1, 16'h0000);
    expect_val("R11 unit1 flag held off", S_FLAG, 16'h0000);
    expect_val("R12 tick in split", S_BAUD, 16'h0001);
    step(1);
    expect_val("R12 tick drops", S_BAUD, 16'h0000);
    wr(A_HI0, 8'hFF);
    ticks(1);
    expect_val("R11 high byte wrap", S_CNT0, 16'h0015);
    expect_val("R11 flag1 from high byte", S_FLAG, 16'h0002);
    wr(A_MODE, 8'h33);
    ticks(3);
    expect_val("R11 unit1 stopped", S_CNT1, 16'h0001);
    expect_val("R11 unit0 split runs", S_CNT0, 16'h0318);

    step(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule